// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block keeps the privilege history of a hart as a small stack of privilege-level and interrupt-enable pairs. Level 0 is the mode the hart runs in now. Levels 1 and up hold the modes that a trap interrupted. A trap request pushes the stack. It switches the hart to machine mode with interrupts off, records the faulting PC and the cause, and redirects the PC to a vector. The vector depends on the privilege level the trap came from. A return request pops the stack. The topmost entry refills with user mode and interrupts on.

The surrounding core selects which trap to take, decodes CSR accesses and translates addresses. It presents one trap or return request per cycle. It reads the updated fields and the next PC from the block's registered outputs in the cycle after the request. The stack depth, data width, cause width, base vector, vector stride and reset offset are all parameters.

Top module: `priv_trap_ctrl`

## Requirements
- R1: When `trap_req` is high at a clock edge, the stack shifts up. Each level k≥1 takes the old level k-1. Level 0 becomes machine privilege with interrupt enable 0. Privilege encoding: user = 0, supervisor = 1, machine = 3. Level k occupies bits [2k+1:2k] of `prv_stack` and bit k of `ie_stack`.
- R2: When `ret_req` is high and `trap_req` is low at a clock edge, the stack shifts down. Each level k below the top takes the old level k+1. The top level becomes user privilege with enable 1.
- R3: On a taken trap, `next_pc` becomes BASE_VEC + VEC_STRIDE × (the level-0 privilege held before the trap). The defaults are BASE_VEC = 0x2000 and VEC_STRIDE = 0x40.
- R4: On a taken trap, `epc` takes `trap_pc` and `cause` takes `trap_cause`. Neither changes at any other time except reset.
- R5: `resv_clear` is high for exactly the one cycle after each edge at which a trap was taken, and is low otherwise.
- R6: A synchronous reset (`rst` high at an edge) sets level 0 to machine and every other level to user. It clears all enables, `mprv`, `epc`, `cause` and `resv_clear`, and sets `next_pc` to BASE_VEC + RESET_OFS (default 0x2100).
- R7: When `trap_req` and `ret_req` are high in the same cycle, only the trap takes effect.
- R8: `mprv_set` sets `mprv` at the next edge. A taken trap clears `mprv` and overrides `mprv_set`. A return leaves `mprv` unchanged.
- R9: In a cycle with no trap, no return and no `mprv_set`, the stack, `mprv`, `next_pc`, `epc` and `cause` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_req | input | 1 | Take a trap this cycle |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_pc | input | XLEN | PC of the faulting instruction |
| ret_req | input | 1 | Return from trap this cycle |
| mprv_set | input | 1 | Set the modify-privilege bit |
| next_pc | output | XLEN | PC the hart fetches from next |
| prv_stack | output | 2*DEPTH | Privilege of each stack level, level 0 in the low bits |
| ie_stack | output | DEPTH | Interrupt enable of each stack level |
| mprv | output | 1 | Modify-privilege bit |
| epc | output | XLEN | Saved exception PC |
| cause | output | CAUSE_W | Saved trap cause |
| resv_clear | output | 1 | One-cycle pulse that drops any load reservation |

## Verification
The properties assume that `rst` is high at the first clock edge. They also assume that request inputs are settled and known at every edge, so each edge sees exactly one of reset, trap, return, mprv set, or idle. The bench drives every input at the falling edge from one driver task and holds reset for the first cycles. Its stimulus sometimes raises trap and return together, and sometimes raises mprv_set together with a trap. This covers the conflicting combinations the properties rely on.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

   typedef enum logic [1:0] {
      PL_USER  = 2'd0,
      PL_SUPER = 2'd1,
      PL_HYPER = 2'd2,
      PL_MACH  = 2'd3
   } priv_lvl_e;

   typedef struct packed {
      priv_lvl_e prv;
      logic      ie;
   } lvl_entry_t;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2
   } stack_op_e;

endpackage

// File: rtl/trap_level_stack.sv
module trap_level_stack
   import priv_trap_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  stack_op_e          op,
   output logic [2*DEPTH-1:0] prv_flat,
   output logic [DEPTH-1:0]   ie_flat,
   output priv_lvl_e          cur_prv
);

   lvl_entry_t lvl_q [DEPTH];

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
         lvl_entry_t below_v;
         lvl_entry_t above_v;
         lvl_entry_t rst_v;

         if (k == 0) begin : g_bottom
            assign below_v = '{prv: PL_MACH, ie: 1'b0};
            assign rst_v   = '{prv: PL_MACH, ie: 1'b0};
         end else begin : g_mid_lo
            assign below_v = lvl_q[k-1];
            assign rst_v   = '{prv: PL_USER, ie: 1'b0};
         end

         if (k == DEPTH - 1) begin : g_top
            assign above_v = '{prv: PL_USER, ie: 1'b1};
         end else begin : g_mid_hi
            assign above_v = lvl_q[k+1];
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               lvl_q[k] <= rst_v;
            end else begin
               case (op)
                  OP_PUSH: lvl_q[k] <= below_v;
                  OP_POP:  lvl_q[k] <= above_v;
                  default: lvl_q[k] <= lvl_q[k];
               endcase
            end
         end

         assign prv_flat[2*k +: 2] = lvl_q[k].prv;
         assign ie_flat[k]         = lvl_q[k].ie;
      end
   endgenerate

   assign cur_prv = lvl_q[0].prv;

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
   import priv_trap_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter logic [XLEN-1:0] BASE_VEC   = 32'h0000_2000,
   parameter int              VEC_STRIDE = 'h40
) (
   input  priv_lvl_e         from_prv,
   output logic [XLEN-1:0]   vec_pc
);

   localparam logic [XLEN-1:0] STRIDE_W = XLEN'(VEC_STRIDE);

   logic [XLEN-1:0] offset_w;

   always_comb begin
      offset_w = '0;
      for (int b = 0; b < 2; b++) begin
         if (from_prv[b]) offset_w = offset_w + (STRIDE_W << b);
      end
   end

   assign vec_pc = BASE_VEC + offset_w;

endmodule

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs #(
   parameter int              XLEN      = 32,
   parameter int              CAUSE_W   = 5,
   parameter logic [XLEN-1:0] RESET_PC  = 32'h0000_2100
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               take_trap,
   input  logic               set_mprv,
   input  logic [XLEN-1:0]    vec_pc,
   input  logic [XLEN-1:0]    fault_pc,
   input  logic [CAUSE_W-1:0] fault_cause,
   output logic [XLEN-1:0]    pc_q,
   output logic [XLEN-1:0]    epc_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic               mprv_q,
   output logic               resv_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= RESET_PC;
         epc_q   <= '0;
         cause_q <= '0;
         resv_q  <= 1'b0;
      end else begin
         resv_q <= take_trap;
         if (take_trap) begin
            pc_q    <= vec_pc;
            epc_q   <= fault_pc;
            cause_q <= fault_cause;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)            mprv_q <= 1'b0;
      else if (take_trap) mprv_q <= 1'b0;
      else if (set_mprv)  mprv_q <= 1'b1;
   end

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
   import priv_trap_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              CAUSE_W    = 5,
   parameter int              DEPTH      = 3,
   parameter logic [XLEN-1:0] BASE_VEC   = 32'h0000_2000,
   parameter int              VEC_STRIDE = 'h40,
   parameter int              RESET_OFS  = 'h100
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trap_req,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic               ret_req,
   input  logic               mprv_set,
   output logic [XLEN-1:0]    next_pc,
   output logic [2*DEPTH-1:0] prv_stack,
   output logic [DEPTH-1:0]   ie_stack,
   output logic               mprv,
   output logic [XLEN-1:0]    epc,
   output logic [CAUSE_W-1:0] cause,
   output logic               resv_clear
);

   localparam logic [XLEN-1:0] RESET_PC = BASE_VEC + XLEN'(RESET_OFS);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("priv_trap_ctrl: DEPTH must be at least 2");
      end
      if (XLEN < 16) begin : g_bad_xlen
         $error("priv_trap_ctrl: XLEN must be at least 16");
      end
      if (CAUSE_W < 1) begin : g_bad_cause
         $error("priv_trap_ctrl: CAUSE_W must be positive");
      end
      if (RESET_OFS < 4 * VEC_STRIDE) begin : g_bad_ofs
         $error("priv_trap_ctrl: reset offset overlaps the trap vectors");
      end
   endgenerate

   stack_op_e op_w;
   priv_lvl_e cur_prv_w;
   logic [XLEN-1:0] vec_w;

   always_comb begin
      if (trap_req)     op_w = OP_PUSH;
      else if (ret_req) op_w = OP_POP;
      else              op_w = OP_HOLD;
   end

   trap_level_stack #(.DEPTH(DEPTH)) u_stack (
      .clk      (clk),
      .rst      (rst),
      .op       (op_w),
      .prv_flat (prv_stack),
      .ie_flat  (ie_stack),
      .cur_prv  (cur_prv_w)
   );

   trap_vector_gen #(
      .XLEN       (XLEN),
      .BASE_VEC   (BASE_VEC),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_vec (
      .from_prv (cur_prv_w),
      .vec_pc   (vec_w)
   );

   trap_ctx_regs #(
      .XLEN     (XLEN),
      .CAUSE_W  (CAUSE_W),
      .RESET_PC (RESET_PC)
   ) u_ctx (
      .clk         (clk),
      .rst         (rst),
      .take_trap   (trap_req),
      .set_mprv    (mprv_set),
      .vec_pc      (vec_w),
      .fault_pc    (trap_pc),
      .fault_cause (trap_cause),
      .pc_q        (next_pc),
      .epc_q       (epc),
      .cause_q     (cause),
      .mprv_q      (mprv),
      .resv_q      (resv_clear)
   );

endmodule

// File: rtl/priv_trap_ctrl_chk.sv
module priv_trap_ctrl_chk #(
   parameter int              XLEN       = 32,
   parameter int              CAUSE_W    = 5,
   parameter int              DEPTH      = 3,
   parameter logic [XLEN-1:0] BASE_VEC   = 32'h0000_2000,
   parameter int              VEC_STRIDE = 'h40,
   parameter int              RESET_OFS  = 'h100
) (
   input logic               clk,
   input logic               rst,
   input logic               trap_req,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [XLEN-1:0]    trap_pc,
   input logic               ret_req,
   input logic               mprv_set,
   input logic [XLEN-1:0]    next_pc,
   input logic [2*DEPTH-1:0] prv_stack,
   input logic [DEPTH-1:0]   ie_stack,
   input logic               mprv,
   input logic [XLEN-1:0]    epc,
   input logic [CAUSE_W-1:0] cause,
   input logic               resv_clear
);

   localparam logic [XLEN-1:0] STRIDE_W = XLEN'(VEC_STRIDE);

   p_push_r1: assert property (@(posedge clk) disable iff (rst)
      trap_req |=> (prv_stack[1:0] == 2'd3) && !ie_stack[0]
                   && (prv_stack[3:2] == $past(prv_stack[1:0]))
                   && (ie_stack[1] == $past(ie_stack[0])));

   p_pop_r2: assert property (@(posedge clk) disable iff (rst)
      (ret_req && !trap_req) |=> (prv_stack[1:0] == $past(prv_stack[3:2]))
                   && (ie_stack[0] == $past(ie_stack[1]))
                   && (prv_stack[2*DEPTH-1 -: 2] == 2'd0) && ie_stack[DEPTH-1]);

   p_vector_r3: assert property (@(posedge clk) disable iff (rst)
      trap_req |=> next_pc == BASE_VEC + STRIDE_W * XLEN'($past(prv_stack[1:0])));

   p_save_r4: assert property (@(posedge clk) disable iff (rst)
      trap_req |=> (epc == $past(trap_pc)) && (cause == $past(trap_cause)));

   p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      trap_req |=> resv_clear);

   p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      !trap_req |=> !resv_clear);

   p_reset_r6: assert property (@(posedge clk)
      rst |=> (next_pc == BASE_VEC + XLEN'(RESET_OFS)) && (prv_stack[1:0] == 2'd3)
              && (ie_stack == '0) && !mprv && !resv_clear && (epc == '0));

   p_mprv_r8: assert property (@(posedge clk) disable iff (rst)
      (mprv_set && !trap_req) |=> mprv);

   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!trap_req && !ret_req && !mprv_set) |=> $stable(prv_stack) && $stable(ie_stack)
              && $stable(next_pc) && $stable(epc) && $stable(cause) && $stable(mprv));

endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk #(
   .XLEN       (XLEN),
   .CAUSE_W    (CAUSE_W),
   .DEPTH      (DEPTH),
   .BASE_VEC   (BASE_VEC),
   .VEC_STRIDE (VEC_STRIDE),
   .RESET_OFS  (RESET_OFS)
) u_chk (.*);

// File: tb/priv_trap_ctrl_bench.sv
`timescale 1ns/1ps
module priv_trap_ctrl_bench;

   localparam int XLEN  = 32;
   localparam int CW    = 5;
   localparam int DEPTH = 3;
   localparam logic [31:0] BASE = 32'h0000_2000;

   typedef struct packed {
      logic [31:0] pc;
      logic [5:0]  prv;
      logic [2:0]  ie;
      logic        mprv;
      logic [31:0] epc;
      logic [4:0]  cause;
      logic        resv;
      logic [15:0] tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trap_req = 1'b0;
   logic [CW-1:0] trap_cause = '0;
   logic [XLEN-1:0] trap_pc = '0;
   logic ret_req = 1'b0;
   logic mprv_set = 1'b0;
   logic [XLEN-1:0] next_pc;
   logic [2*DEPTH-1:0] prv_stack;
   logic [DEPTH-1:0] ie_stack;
   logic mprv;
   logic [XLEN-1:0] epc;
   logic [CW-1:0] cause;
   logic resv_clear;

   int n_run = 0;
   int n_fail = 0;
   exp_t q[$];
   exp_t m;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   priv_trap_ctrl u_priv_trap_ctrl (
      .clk(clk), .rst(rst), .trap_req(trap_req), .trap_cause(trap_cause),
      .trap_pc(trap_pc), .ret_req(ret_req), .mprv_set(mprv_set),
      .next_pc(next_pc), .prv_stack(prv_stack), .ie_stack(ie_stack),
      .mprv(mprv), .epc(epc), .cause(cause), .resv_clear(resv_clear)
   );

   // driver: one operation per cycle, expected state pushed to the scoreboard
   task automatic step(input logic r, input logic t, input logic rt, input logic ms,
                       input logic [31:0] fpc, input logic [4:0] fc, input logic [15:0] tg);
      @(negedge clk);
      rst = r; trap_req = t; ret_req = rt; mprv_set = ms; trap_pc = fpc; trap_cause = fc;
      if (r) begin
         m.pc = BASE + 32'h100; m.prv = 6'b00_00_11; m.ie = 3'b000;
         m.mprv = 1'b0; m.epc = '0; m.cause = '0; m.resv = 1'b0;
      end else begin
         m.resv = t;
         if (t) begin
            m.pc = BASE + 32'h40 * 32'(m.prv[1:0]);
            m.epc = fpc; m.cause = fc;
            m.prv = {m.prv[3:0], 2'b11};
            m.ie = {m.ie[1:0], 1'b0};
            m.mprv = 1'b0;
         end else begin
            if (rt) begin
               m.prv = {2'b00, m.prv[5:2]};
               m.ie = {1'b1, m.ie[2:1]};
            end
            if (ms) m.mprv = 1'b1;
         end
      end
      m.tag = tg;
      q.push_back(m);
   endtask

   task automatic chk_field(input logic [15:0] tg, input string nm,
                            input logic [31:0] act, input logic [31:0] exp, inout bit bad);
      if (act !== exp) begin
         $display("FAIL %s %s actual=%h expected=%h", tg, nm, act, exp);
         bad = 1'b1;
      end
   endtask

   // monitor: pops one expectation per edge and compares after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 1'b0;
            n_run++;
            chk_field(e.tag == "R6" ? "R6" : "R3", "next_pc", next_pc, e.pc, bad);
            chk_field(e.tag, "prv_stack", 32'(prv_stack), 32'(e.prv), bad);
            chk_field(e.tag, "ie_stack", 32'(ie_stack), 32'(e.ie), bad);
            chk_field(e.tag == "R6" ? "R6" : "R8", "mprv", 32'(mprv), 32'(e.mprv), bad);
            chk_field(e.tag == "R6" ? "R6" : "R4", "epc", epc, e.epc, bad);
            chk_field(e.tag == "R6" ? "R6" : "R4", "cause", 32'(cause), 32'(e.cause), bad);
            chk_field(e.tag == "R6" ? "R6" : "R5", "resv_clear", 32'(resv_clear), 32'(e.resv), bad);
            if (bad) n_fail++;
         end
      end
   end

   initial begin
      m = '0;
      step(1, 0, 0, 0, 0, 0, "R6");            // R6 reset state
      step(1, 1, 1, 1, 32'h55, 5'd3, "R6");    // R6 reset overrides requests
      step(0, 0, 0, 0, 0, 0, "R9");            // R9 idle hold
      step(0, 1, 0, 0, 32'h1234, 5'd2, "R1");  // R1/R3 trap from machine: vec 0x20c0
      step(0, 0, 0, 0, 0, 0, "R5");            // R5 pulse ends
      step(0, 0, 1, 0, 0, 0, "R2");            // R2 pops
      step(0, 0, 1, 0, 0, 0, "R2");
      step(0, 0, 1, 0, 0, 0, "R2");            // R2 enable reaches level 0
      step(0, 0, 0, 1, 0, 0, "R8");            // R8 mprv set
      step(0, 0, 1, 0, 0, 0, "R8");            // R8 return keeps mprv
      step(0, 1, 0, 1, 32'hABC0, 5'd11, "R8"); // R8 trap clears mprv, R3 vec from user
      step(0, 1, 1, 0, 32'hBEE4, 5'd7, "R7");  // R7 trap wins over return
      step(0, 1, 0, 0, 32'hCAF0, 5'd1, "R1");  // R1 deep push, R5 back-to-back pulse
      step(0, 0, 0, 0, 0, 0, "R9");            // R9 hold, R4 epc stable
      for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R2");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 32'h100 + 32'(i * 4), 5'(i + 20), "R1");
      step(0, 0, 0, 0, 0, 0, "R9");
      step(1, 0, 0, 0, 0, 0, "R6");            // R6 reset mid-run
      step(0, 0, 0, 0, 0, 0, "R9");
      @(negedge clk);
      rst = 1'b0; trap_req = 1'b0; ret_req = 1'b0; mprv_set = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            $display("FAIL watchdog expired actual=timeout expected=done");
            n_run++;
            n_fail++;
         end
      join_any
      if (q.size() != 0 && done) begin
         $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
         n_fail++;
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule